// File: doc/BRIEF.md
# Partitionable SRAM Bank Router

This block sits in front of five equal on-chip RAM banks. It shares them among three requesters: an instruction tightly-coupled port, a data tightly-coupled port and a shared system-bus port. A configuration write sets how many whole banks (0, 1 or 2) serve the instruction port and how many serve the data port. Every bank not taken by those two ports serves the shared bus window, and the highest bank can never be given away. The banks keep their contents when ownership changes, so after a repartition a region offset may be backed by a different physical bank.

The shared bus reaches every region through fixed 1 MB windows. Bits [31:20] of the address select the window. The instruction-port banks are visible at 0x0010_0000, the data-port banks at 0x0020_0000 and the shared region at 0x0030_0000. A sticky remap control adds an alias of the shared region at 0x0000_0000. The block decodes each address, steers the write enable and byte strobes to one bank, and returns the read data and an error flag one cycle later. The bank size is `4 << BANK_AW` bytes. The default `BANK_AW=8` gives 1 KB banks for simulation, and `BANK_AW=12` gives 16 KB banks (80 KB in total).

Top module: `sram_bank_router`

## Requirements
- R1: Out of reset both tightly-coupled sizes are zero. All five banks then belong to the shared region, so shared offsets 0 to 5 banks minus one byte are valid, and every access on either tightly-coupled port returns an error.
- R2: A configuration write (`cfg_we`=1) loads `cfg_ibanks` and `cfg_dbanks` as bank counts. A value of 3 is clamped to 2.
- R3: With an instruction bank count ni, instruction offset slot k (the offset divided by the bank size) uses physical bank k when k < ni. A larger slot gives an error and writes nothing.
- R4: With a data bank count nd, data offset slot k uses physical bank ni+k when k < nd. A larger slot gives an error and writes nothing.
- R5: The shared region holds 5-ni-nd banks. Shared slot k uses bank ni+nd+k, and a slot at or beyond the region size gives an error.
- R6: On the shared bus, window 0x001 reaches the instruction banks and window 0x002 reaches the data banks. Both use the same slot rules as R3 and R4.
- R7: Window 0x003 always reaches the shared region. Window 0x000 reaches it only after `remap_set` has been seen high, and that stays true until reset.
- R8: Shared-bus accesses to any other window return an error.
- R9: Each accepted request produces `*_rvalid` on the next cycle. With it come `*_err` and, for a read, the full word in `*_rdata`.
- R10: When the shared port and a valid tightly-coupled access target the same physical bank in one cycle, `s_ready` is low, the shared request is not performed, and the tightly-coupled access proceeds.
- R11: A write changes only the bytes whose strobe bit is set (bit n covers data bits 8n+7:8n).
- R12: Repartitioning never moves stored data. A bank read through its new owner returns what was written through its old owner.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cfg_we | input | 1 | Load bank counts |
| cfg_ibanks | input | 2 | Requested instruction bank count |
| cfg_dbanks | input | 2 | Requested data bank count |
| remap_set | input | 1 | Enable the zero-based shared alias (sticky) |
| i_req | input | 1 | Instruction port request |
| i_we | input | 1 | Instruction port write |
| i_be | input | DW/8 | Instruction port byte strobes |
| i_addr | input | TAW | Instruction port byte offset |
| i_wdata | input | DW | Instruction port write data |
| i_rvalid | output | 1 | Instruction port response valid |
| i_err | output | 1 | Instruction port error |
| i_rdata | output | DW | Instruction port read data |
| d_req | input | 1 | Data port request |
| d_we | input | 1 | Data port write |
| d_be | input | DW/8 | Data port byte strobes |
| d_addr | input | TAW | Data port byte offset |
| d_wdata | input | DW | Data port write data |
| d_rvalid | output | 1 | Data port response valid |
| d_err | output | 1 | Data port error |
| d_rdata | output | DW | Data port read data |
| s_req | input | 1 | Shared bus request |
| s_we | input | 1 | Shared bus write |
| s_be | input | DW/8 | Shared bus byte strobes |
| s_addr | input | 32 | Shared bus byte address |
| s_wdata | input | DW | Shared bus write data |
| s_ready | output | 1 | Shared request accepted this cycle |
| s_rvalid | output | 1 | Shared response valid |
| s_err | output | 1 | Shared error |
| s_rdata | output | DW | Shared read data |

## Verification
The assertions check these properties on every cycle: the clamped bank counts never exceed two, the remap flag never clears, no bank is ever granted to more than one port, a stall happens only while a tightly-coupled port is requesting, and out-of-range instruction offsets always return an error. The bench scenarios show the rest. They cover the mapping of slots to physical banks under each partition, data surviving a repartition, the alias windows, byte-strobe merging, and the fact that an erroring write leaves the target bank untouched. The bench checks these against its own memory model.

// File: rtl/sram_bank_router.sv
module sram_bank_router #(
  parameter int BANK_AW = 8,
  parameter int NBANK = 5,
  parameter int TCM_MAX = 2,
  parameter int DW = 32,
  localparam int NBE = DW / 8,
  localparam int OB = BANK_AW + $clog2(NBE),
  localparam int TAW = OB + $clog2(TCM_MAX)
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           cfg_we,
  input  logic [1:0]     cfg_ibanks,
  input  logic [1:0]     cfg_dbanks,
  input  logic           remap_set,
  input  logic           i_req,
  input  logic           i_we,
  input  logic [NBE-1:0] i_be,
  input  logic [TAW-1:0] i_addr,
  input  logic [DW-1:0]  i_wdata,
  output logic           i_rvalid,
  output logic           i_err,
  output logic [DW-1:0]  i_rdata,
  input  logic           d_req,
  input  logic           d_we,
  input  logic [NBE-1:0] d_be,
  input  logic [TAW-1:0] d_addr,
  input  logic [DW-1:0]  d_wdata,
  output logic           d_rvalid,
  output logic           d_err,
  output logic [DW-1:0]  d_rdata,
  input  logic           s_req,
  input  logic           s_we,
  input  logic [NBE-1:0] s_be,
  input  logic [31:0]    s_addr,
  input  logic [DW-1:0]  s_wdata,
  output logic           s_ready,
  output logic           s_rvalid,
  output logic           s_err,
  output logic [DW-1:0]  s_rdata
);
  localparam int BW = $clog2(NBANK);
  localparam int SW = 20 - OB;

  logic [BW-1:0] ni_q, nd_q;
  logic          remap_q;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      ni_q <= '0;
      nd_q <= '0;
      remap_q <= 1'b0;
    end else begin
      if (cfg_we) begin
        ni_q <= (int'(cfg_ibanks) > TCM_MAX) ? BW'(TCM_MAX) : BW'(cfg_ibanks);
        nd_q <= (int'(cfg_dbanks) > TCM_MAX) ? BW'(TCM_MAX) : BW'(cfg_dbanks);
      end
      if (remap_set) remap_q <= 1'b1;
    end

  logic [TAW-OB-1:0] i_slot, d_slot;
  logic [BW-1:0]     i_bank, d_bank;
  logic              i_ok, d_ok;
  assign i_slot = i_addr[TAW-1:OB];
  assign d_slot = d_addr[TAW-1:OB];
  assign i_ok   = i_req && (BW'(i_slot) < ni_q);
  assign d_ok   = d_req && (BW'(d_slot) < nd_q);
  assign i_bank = BW'(i_slot);
  assign d_bank = ni_q + BW'(d_slot);

  logic [SW-1:0] s_slot;
  logic [BW-1:0] s_base, s_cnt, s_bank;
  logic          s_hit, s_inrange, s_conf, s_acc, s_go;
  assign s_slot = s_addr[19:OB];

  always_comb begin
    s_hit = 1'b1;
    s_base = ni_q + nd_q;
    s_cnt = BW'(NBANK) - ni_q - nd_q;
    case (s_addr[31:20])
      12'h000: s_hit = remap_q;
      12'h001: begin s_base = '0; s_cnt = ni_q; end
      12'h002: begin s_base = ni_q; s_cnt = nd_q; end
      12'h003: ;
      default: s_hit = 1'b0;
    endcase
  end

  assign s_inrange = s_hit && (s_slot < SW'(s_cnt));
  assign s_bank    = s_base + BW'(s_slot);
  assign s_conf    = s_inrange && ((i_ok && i_bank == s_bank) || (d_ok && d_bank == s_bank));
  assign s_ready   = !s_conf;
  assign s_acc     = s_req && s_ready;
  assign s_go      = s_acc && s_inrange;

  logic [DW-1:0] bank_rd [NBANK];

  for (genvar b = 0; b < NBANK; b++) begin : g_bank
    logic               sel_i, sel_d, sel_s, en, we;
    logic [NBE-1:0]     be;
    logic [DW-1:0]      wd, rd_q;
    logic [BANK_AW-1:0] wa;
    logic [DW-1:0]      mem [2**BANK_AW];

    assign sel_i = i_ok && i_bank == BW'(b);
    assign sel_d = d_ok && d_bank == BW'(b);
    assign sel_s = s_go && s_bank == BW'(b);

    always_comb begin
      en = 1'b1; we = 1'b0; be = '0; wd = '0; wa = '0;
      if (sel_i)      begin we = i_we; be = i_be; wd = i_wdata; wa = i_addr[OB-1:2]; end
      else if (sel_d) begin we = d_we; be = d_be; wd = d_wdata; wa = d_addr[OB-1:2]; end
      else if (sel_s) begin we = s_we; be = s_be; wd = s_wdata; wa = s_addr[OB-1:2]; end
      else en = 1'b0;
    end

    always_ff @(posedge clk) begin
      if (en && we)
        for (int k = 0; k < NBE; k++)
          if (be[k]) mem[wa][8*k +: 8] <= wd[8*k +: 8];
      if (en) rd_q <= mem[wa];
    end
    assign bank_rd[b] = rd_q;

    // R10
    bank_single_owner_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0({sel_i, sel_d, sel_s}));
  end

  logic [BW-1:0] i_sel_q, d_sel_q, s_sel_q;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      {i_rvalid, i_err, d_rvalid, d_err, s_rvalid, s_err} <= '0;
      {i_sel_q, d_sel_q, s_sel_q} <= '0;
    end else begin
      i_rvalid <= i_req;
      i_err    <= i_req && !i_ok;
      d_rvalid <= d_req;
      d_err    <= d_req && !d_ok;
      s_rvalid <= s_acc;
      s_err    <= s_acc && !s_inrange;
      if (i_ok) i_sel_q <= i_bank;
      if (d_ok) d_sel_q <= d_bank;
      if (s_go) s_sel_q <= s_bank;
    end

  assign i_rdata = bank_rd[i_sel_q];
  assign d_rdata = bank_rd[d_sel_q];
  assign s_rdata = bank_rd[s_sel_q];

  logic unused_lo;
  assign unused_lo = ^{i_addr[1:0], d_addr[1:0], s_addr[1:0]};

  // R2
  tcm_limit_chk: assert property (@(posedge clk) disable iff (!rst_n)
    int'(ni_q) <= TCM_MAX && int'(nd_q) <= TCM_MAX);
  // R7
  remap_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    remap_q |=> remap_q);
  // R10
  stall_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !s_ready |-> (i_req || d_req));
  // R9
  i_resp_chk: assert property (@(posedge clk) disable iff (!rst_n)
    i_req |=> i_rvalid);
  // R9
  s_resp_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (s_req && s_ready) |=> s_rvalid);
  // R3
  i_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (i_req && int'(i_addr >> OB) >= int'(ni_q)) |=> i_err);
endmodule

// File: tb/sim_sram_bank_router.sv
module sim_sram_bank_router;
  localparam int BAW = 8;
  localparam int WPB = 2**BAW;
  localparam int BB = WPB * 4;
  localparam int TAW = 11;

  logic clk = 1'b0, rst_n = 1'b0;
  logic cfg_we = 0, remap_set = 0;
  logic [1:0] cfg_ibanks = 0, cfg_dbanks = 0;
  logic i_req = 0, i_we = 0, d_req = 0, d_we = 0, s_req = 0, s_we = 0;
  logic [3:0] i_be = 0, d_be = 0, s_be = 0;
  logic [TAW-1:0] i_addr = 0, d_addr = 0;
  logic [31:0] s_addr = 0, i_wdata = 0, d_wdata = 0, s_wdata = 0;
  logic i_rvalid, i_err, d_rvalid, d_err, s_ready, s_rvalid, s_err;
  logic [31:0] i_rdata, d_rdata, s_rdata;

  sram_bank_router #(.BANK_AW(BAW)) u0 (.*);

  always #10 clk = ~clk;

  int checks = 0, errors = 0;
  bit done = 0;
  logic [31:0] mdl [5*WPB];
  int ni = 0, nd = 0;
  bit rmp = 0;

  task automatic chk(input bit ok, input string rq, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", rq, act, exp);
    end
  endtask

  function automatic int mslot(input int slot, input int cnt, input int base, input int off);
    if (slot >= cnt) return -1;
    return (base + slot) * WPB + (off % BB) / 4;
  endfunction

  function automatic int mindex(input int p, input logic [31:0] a);
    int off, win;
    off = int'(a[19:0]);
    win = int'(a[31:20]);
    if (p == 0) return mslot(off / BB, ni, 0, off);
    if (p == 1) return mslot(off / BB, nd, ni, off);
    case (win)
      0: return rmp ? mslot(off / BB, 5 - ni - nd, ni + nd, off) : -1;
      1: return mslot(off / BB, ni, 0, off);
      2: return mslot(off / BB, nd, ni, off);
      3: return mslot(off / BB, 5 - ni - nd, ni + nd, off);
      default: return -1;
    endcase
  endfunction

  function automatic logic [31:0] merge(input logic [31:0] o, input logic [31:0] n, input logic [3:0] be);
    logic [31:0] r = o;
    for (int k = 0; k < 4; k++) if (be[k]) r[8*k +: 8] = n[8*k +: 8];
    return r;
  endfunction

  task automatic access(input int p, input bit we, input logic [3:0] be,
                        input logic [31:0] a, input logic [31:0] wd, input string rq);
    int idx;
    logic ev, rv;
    logic [31:0] rd;
    idx = mindex(p, a);
    if (p == 0) begin i_req = 1; i_we = we; i_be = be; i_addr = a[TAW-1:0]; i_wdata = wd; end
    else if (p == 1) begin d_req = 1; d_we = we; d_be = be; d_addr = a[TAW-1:0]; d_wdata = wd; end
    else begin
      s_req = 1; s_we = we; s_be = be; s_addr = a; s_wdata = wd;
      #1 chk(s_ready == 1'b1, "R10 no stall when alone", 32'(s_ready), 1);
    end
    @(negedge clk);
    if (p == 0) begin rv = i_rvalid; ev = i_err; rd = i_rdata; i_req = 0; end
    else if (p == 1) begin rv = d_rvalid; ev = d_err; rd = d_rdata; d_req = 0; end
    else begin rv = s_rvalid; ev = s_err; rd = s_rdata; s_req = 0; end
    chk(rv == 1'b1, {"R9 rvalid ", rq}, 32'(rv), 1);
    chk(ev == (idx < 0), {"err ", rq}, 32'(ev), 32'(idx < 0));
    if (idx >= 0) begin
      if (we) mdl[idx] = merge(mdl[idx], wd, be);
      else chk(rd == mdl[idx], {"rdata ", rq}, rd, mdl[idx]);
    end
  endtask

  task automatic set_cfg(input int a, input int b);
    cfg_we = 1; cfg_ibanks = 2'(a); cfg_dbanks = 2'(b);
    @(negedge clk);
    cfg_we = 0;
    ni = (a > 2) ? 2 : a;
    nd = (b > 2) ? 2 : b;
  endtask

  task automatic do_remap();
    remap_set = 1;
    @(negedge clk);
    remap_set = 0;
    rmp = 1;
  endtask

  initial begin
    #(200000 * 20);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog actual=%h expected=%h", 32'd0, 32'd1);
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'h1234_5EED));
    repeat (3) @(negedge clk);
    chk(!i_rvalid && !d_rvalid && !s_rvalid, "R1 reset outputs", 32'({i_rvalid, d_rvalid, s_rvalid}), 0);
    rst_n = 1;
    @(negedge clk);
    chk(s_ready == 1'b1, "R1 reset ready", 32'(s_ready), 1);
    // R1: all five banks reachable through the shared window
    for (int k = 0; k < 5 * WPB; k++)
      access(2, 1, 4'hF, 32'h0030_0000 + 32'(k * 4), 32'hA500_0000 ^ 32'(k * 7919), "R1 fill");
    access(2, 0, 0, 32'h0030_0000 + 32'(4 * BB + 8), 0, "R1 top bank");
    access(2, 0, 0, 32'h0030_0000 + 32'(5 * BB), 0, "R5 beyond 5 banks");
    access(0, 0, 0, 32'h0, 0, "R1 itcm empty");
    access(1, 0, 0, 32'h4, 0, "R1 dtcm empty");
    access(2, 0, 0, 32'h0040_0000, 0, "R8 bad window");
    access(2, 0, 0, 32'h00F0_0010, 0, "R8 bad window high");
    access(2, 0, 0, 32'h0000_0010, 0, "R7 no alias before remap");
    set_cfg(3, 1);
    access(0, 0, 0, 32'(BB + 12), 0, "R2 R12 itcm slot1 clamped");
    access(1, 0, 0, 32'h20, 0, "R4 dtcm slot0 bank2");
    access(1, 1, 4'hF, 32'(BB), 32'hDEAD_BEEF, "R4 dtcm out of range write");
    access(2, 0, 0, 32'h0030_0000, 0, "R4 R5 shared slot0 untouched");
    access(2, 0, 0, 32'h0030_0000 + 32'(2 * BB), 0, "R5 shared slot2 error");
    access(2, 0, 0, 32'h0010_0000 + 32'(BB + 4), 0, "R6 itcm alias");
    access(2, 0, 0, 32'h0020_0000 + 32'h40, 0, "R6 dtcm alias");
    access(0, 1, 4'b0101, 32'h10, 32'h1122_3344, "R11 strobe write");
    access(0, 0, 0, 32'h10, 0, "R11 strobe read");
    do_remap();
    access(2, 0, 0, 32'h0000_0000 + 32'(BB + 4), 0, "R7 zero alias");
    @(negedge clk);
    access(2, 0, 0, 32'h0000_0008, 0, "R7 alias sticky");
    // R10 conflict: itcm and shared alias on bank 0
    i_req = 1; i_we = 0; i_addr = 11'h8;
    s_req = 1; s_we = 1; s_be = 4'hF; s_addr = 32'h0010_0008; s_wdata = 32'h5555_AAAA;
    #1 chk(s_ready == 1'b0, "R10 stall", 32'(s_ready), 0);
    @(negedge clk);
    chk(i_rvalid && !i_err && i_rdata == mdl[2], "R10 tcm wins", i_rdata, mdl[2]);
    chk(s_rvalid == 1'b0, "R10 shared not accepted", 32'(s_rvalid), 0);
    i_req = 0;
    #1 chk(s_ready == 1'b1, "R10 ready after", 32'(s_ready), 1);
    @(negedge clk);
    s_req = 0;
    chk(s_rvalid && !s_err, "R10 shared done", 32'(s_rvalid), 1);
    mdl[2] = 32'h5555_AAAA;
    access(0, 0, 0, 32'h8, 0, "R10 shared write landed");
    // R12 repartition back to all shared keeps contents
    set_cfg(0, 0);
    access(2, 0, 0, 32'h0030_0000 + 32'h10, 0, "R12 contents kept");
    for (int n = 0; n < 3000; n++) begin
      int p, win;
      logic [31:0] a;
      if ($urandom % 60 == 0) set_cfg(int'($urandom % 4), int'($urandom % 4));
      p = int'($urandom % 3);
      if (p < 2) a = ($urandom % (2 * BB)) & ~32'h3;
      else begin
        win = int'($urandom % 5);
        a = (32'(win) << 20) | (($urandom % (6 * BB)) & ~32'h3);
      end
      access(p, 1'($urandom), 4'($urandom), a, $urandom, "R3 R4 R5 R6 R11 random");
    end
    done = 1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule